// File: doc/BRIEF.md
# Serial PMIC Register Bridge

This block lets a processor on a simple memory-mapped bus reach the registers of a remote power-management device across a narrow serial link. Bus writes that land in the slave window are posted. They enter a small write queue that a serial shifter drains in order, one frame per write. Reads are started by writing a slave offset to a command register. A busy flag goes high at once and stays high until the serial read finishes. The completed word holds the 16 returned data bits and a 15-bit tag that echoes the address. Software can use the tag to confirm which register answered.

The address mode is chosen by a parameter. The 10-bit mode has a 4 KiB window at bus offset 0x8000 and a single slave. The 12-bit mode has a 16 KiB window at 0x8000. The 15-bit mode has a 128 KiB window at 0x20000. In the 12-bit and 15-bit modes the two most significant word-address bits pick one of three slaves, and each slave has its own active-low chip select. A second parameter selects how the echo tag is formed: from command bits 16:2, which is the default, or from command bits 14:0. The requirements below apply to the default 12-bit mode with the shifted echo and a queue depth of 4.

Top module: `spb_bridge`

## Requirements
- R1: After reset the queue status register at bus offset 0x30 reads 0x00000400, meaning empty with no overflow. The read result register at 0x2C reads 0, and all three chip selects are high.
- R2: A bus write of a legal offset to the command register at 0x28 starts a serial read with no other trigger. Bit 31 of the result register reads 1 from the very next cycle, and it returns to 0 only when that read frame has completed.
- R3: When a read completes, the result register holds the returned data in bits 15:0, command bits 16:2 in bits 30:16, and 0 in bit 31.
- R4: A read command or slave-window write whose offset is at or beyond 16 KiB starts no frame. It leaves the busy flag and the result register unchanged, and it does not enter the queue.
- R5: An offset whose word-address bits 11:10 equal 3, meaning no such slave exists, is illegal in the same way as in R4.
- R6: A bus write to 0x8000 plus a legal offset queues the word address (offset bits 13:2) and the data (bits 15:0). Queued writes reach the slave in order. A pending read starts only once the queue is empty, so it returns the latest value written.
- R7: In the queue status register, bit 11 is full (4 entries held) and bit 10 is empty. The two are never both set.
- R8: A window write that arrives while the queue is full is dropped. It sets bit 12 of the status register, and that bit stays set until reset.
- R9: A frame drives low exactly one chip select, ser_cs_n[i], where i is word-address bits 11:10. All chip selects are high between frames.
- R10: A frame is 29 bits, sent MSB first on ser_mosi. The first bit is 1 for a read and 0 for a write, followed by 12 word-address bits and then 16 data bits. The slave samples on the rising edge of ser_clk. During the data bits of a read, the slave drives ser_miso after each falling edge, and ser_clk is low outside frames.
- R11: A read command written while the busy flag is set is ignored. The read already in progress completes with its own tag and data.
- R12: Bus writes below 0x8000, other than to the command register, start no frame and queue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe for one cycle |
| bus_addr | input | 18 | Bus byte address, which also drives the read mux |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Combinational register read data for bus_addr |
| ser_clk | output | 1 | Serial bit clock |
| ser_cs_n | output | 3 | Active-low chip selects, one per slave |
| ser_mosi | output | 1 | Serial data toward the slave |
| ser_miso | input | 1 | Serial data from the slave |

## Verification
A read command and a queued write can be live together: the command arrives while earlier writes are still in the queue or on the wire. The sequencer must then let every queued write finish before the read frame goes out. The bench provokes this in two ways. First, it fires a burst of back-to-back window writes that overfills the queue. Second, it issues a read of the last accepted address the moment the burst ends, and it mixes random writes and reads against a shadow memory. A read is judged correct only if it returns the newest accepted value, carries the right echo tag, and leaves the dropped burst entries unwritten in the slave.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef enum logic [1:0] {
        AM_10B = 2'd0,
        AM_12B = 2'd1,
        AM_15B = 2'd2
    } addr_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_END   = 2'd2
    } sh_state_e;

    localparam logic [17:0] OFS_RD_CMD  = 18'h00028;
    localparam logic [17:0] OFS_RD_DATA = 18'h0002C;
    localparam logic [17:0] OFS_WF_STAT = 18'h00030;

    localparam int BIT_BUSY  = 31;
    localparam int BIT_OVF   = 12;
    localparam int BIT_FULL  = 11;
    localparam int BIT_EMPTY = 10;

    localparam int DATA_W = 16;

    function automatic int win_base(addr_mode_e m);
        return (m == AM_15B) ? 32'h20000 : 32'h08000;
    endfunction

    function automatic int win_bytes(addr_mode_e m);
        case (m)
            AM_10B:  return 4096;
            AM_12B:  return 16384;
            default: return 131072;
        endcase
    endfunction

    function automatic int word_bits(addr_mode_e m);
        case (m)
            AM_10B:  return 10;
            AM_12B:  return 12;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/spb_wfifo.sv
module spb_wfifo #(
    parameter int DEPTH = 4,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   count;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    assign full  = (count == (PW+1)'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spb_shifter.sv
module spb_shifter
    import spb_pkg::*;
#(
    parameter int WA = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_rd,
    input  logic [WA-1:0] addr,
    input  logic [15:0]   data,
    input  logic [1:0]    sel,
    output logic          idle,
    output logic          done,
    output logic          done_rd,
    output logic [15:0]   rx,
    output logic          sclk,
    output logic [2:0]    cs_n,
    output logic          mosi,
    input  logic          miso
);
    localparam int FL = 1 + WA + DATA_W;
    localparam int CW = $clog2(FL);

    sh_state_e       state;
    logic [FL-1:0]   sr;
    logic [CW-1:0]   cnt;
    logic            phase;
    logic            rd_q;
    logic [1:0]      sel_q;

    assign idle    = (state == SH_IDLE);
    assign done    = (state == SH_END);
    assign done_rd = (state == SH_END) && rd_q;
    assign sclk    = (state == SH_SHIFT) && phase;
    assign mosi    = (state == SH_SHIFT) ? sr[FL-1] : 1'b0;
    assign cs_n    = (state == SH_SHIFT) ? ~(3'b001 << sel_q) : 3'b111;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            sr    <= '0;
            cnt   <= '0;
            phase <= 1'b0;
            rd_q  <= 1'b0;
            sel_q <= '0;
            rx    <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        sr    <= {is_rd, addr, (is_rd ? 16'h0000 : data)};
                        rd_q  <= is_rd;
                        sel_q <= sel;
                        cnt   <= '0;
                        phase <= 1'b0;
                        state <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        sr    <= {sr[FL-2:0], 1'b0};
                        rx    <= {rx[14:0], miso};
                        if (cnt == CW'(FL-1)) begin
                            state <= SH_END;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= SH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/spb_bridge.sv
module spb_bridge
    import spb_pkg::*;
#(
    parameter addr_mode_e MODE         = AM_12B,
    parameter bit         ECHO_SHIFTED = 1'b1,
    parameter int         FIFO_DEPTH   = 4,
    parameter int         BUS_AW       = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ser_clk,
    output logic [2:0]        ser_cs_n,
    output logic              ser_mosi,
    input  logic              ser_miso
);
    localparam int  WA    = word_bits(MODE);
    localparam int  BASE  = win_base(MODE);
    localparam int  SIZE  = win_bytes(MODE);
    localparam bit  MULTI = (MODE != AM_10B);
    localparam int  IW    = WA + DATA_W;

    function automatic logic ofs_legal(logic [31:0] ofs);
        if (ofs >= 32'(SIZE)) return 1'b0;
        if (MULTI && (ofs[WA+1 -: 2] == 2'b11)) return 1'b0;
        return 1'b1;
    endfunction

    // bus decode
    logic [31:0] addr32, win_ofs;
    logic        win_hit, win_ok, cmd_hit, cmd_take;
    assign addr32  = 32'(bus_addr);
    assign win_ofs = addr32 - 32'(BASE);
    assign win_hit = bus_we && (addr32 >= 32'(BASE));
    assign win_ok  = win_hit && ofs_legal(win_ofs);
    assign cmd_hit = bus_we && (bus_addr == BUS_AW'(OFS_RD_CMD));

    // write queue
    logic          f_full, f_empty, f_push, f_pop, ovf_set;
    logic [IW-1:0] f_din, f_dout;
    assign f_push  = win_ok && !f_full;
    assign ovf_set = win_ok && f_full;
    assign f_din   = {win_ofs[WA+1:2], bus_wdata[15:0]};

    spb_wfifo #(.DEPTH(FIFO_DEPTH), .W(IW)) u_wfifo (
        .clk   (clk),
        .rst   (rst),
        .push  (f_push),
        .din   (f_din),
        .pop   (f_pop),
        .dout  (f_dout),
        .full  (f_full),
        .empty (f_empty)
    );

    // read sequencer state
    logic          rd_busy, rd_pend, ovf_q;
    logic [WA-1:0] rd_word;
    logic [14:0]   rd_tag, rd_echo, tag_w;
    logic [15:0]   rd_val;

    generate
        if (ECHO_SHIFTED) begin : g_echo_shift
            assign tag_w = bus_wdata[16:2];
        end else begin : g_echo_plain
            assign tag_w = bus_wdata[14:0];
        end
    endgenerate

    assign cmd_take = cmd_hit && ofs_legal(bus_wdata) && !rd_busy;

    // shifter arbitration: queued writes first, read once the queue is empty
    logic          sh_idle, sh_done, sh_done_rd, start_wr, start_rd, sh_start;
    logic [WA-1:0] sh_addr;
    logic [1:0]    sh_sel;
    logic [15:0]   sh_rx;

    assign start_wr = sh_idle && !f_empty;
    assign start_rd = sh_idle && f_empty && rd_pend;
    assign sh_start = start_wr || start_rd;
    assign f_pop    = start_wr;
    assign sh_addr  = start_wr ? f_dout[IW-1:DATA_W] : rd_word;

    generate
        if (MULTI) begin : g_multi
            assign sh_sel = sh_addr[WA-1 -: 2];
        end else begin : g_single
            assign sh_sel = 2'b00;
        end
    endgenerate

    spb_shifter #(.WA(WA)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .is_rd   (start_rd),
        .addr    (sh_addr),
        .data    (f_dout[DATA_W-1:0]),
        .sel     (sh_sel),
        .idle    (sh_idle),
        .done    (sh_done),
        .done_rd (sh_done_rd),
        .rx      (sh_rx),
        .sclk    (ser_clk),
        .cs_n    (ser_cs_n),
        .mosi    (ser_mosi),
        .miso    (ser_miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_busy <= 1'b0;
            rd_pend <= 1'b0;
            rd_word <= '0;
            rd_tag  <= '0;
            rd_echo <= '0;
            rd_val  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (cmd_take) begin
                rd_busy <= 1'b1;
                rd_pend <= 1'b1;
                rd_word <= bus_wdata[WA+1:2];
                rd_tag  <= tag_w;
            end
            if (start_rd) begin
                rd_pend <= 1'b0;
            end
            if (sh_done_rd) begin
                rd_busy <= 1'b0;
                rd_val  <= sh_rx;
                rd_echo <= rd_tag;
            end
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(OFS_RD_DATA)) begin
            bus_rdata = {rd_busy, rd_echo, rd_val};
        end else if (bus_addr == BUS_AW'(OFS_WF_STAT)) begin
            bus_rdata[BIT_OVF]   = ovf_q;
            bus_rdata[BIT_FULL]  = f_full;
            bus_rdata[BIT_EMPTY] = f_empty;
        end
    end

endmodule

// File: rtl/spb_checker.sv
module spb_checker (
    input logic       clk,
    input logic       rst,
    input logic       ser_clk,
    input logic [2:0] ser_cs_n,
    input logic       f_full,
    input logic       f_empty,
    input logic       ovf_q,
    input logic       rd_busy,
    input logic       sh_done
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ser_cs_n)); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(f_full && f_empty)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R8

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && !sh_done) |=> rd_busy); // R2

    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&ser_cs_n) |-> !ser_clk); // R10

endmodule

bind spb_bridge spb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_cs_n (ser_cs_n),
    .f_full   (f_full),
    .f_empty  (f_empty),
    .ovf_q    (ovf_q),
    .rd_busy  (rd_busy),
    .sh_done  (sh_done)
);

// File: tb/tb_spb_bridge.sv
`timescale 1ns/1ps
module tb_spb_bridge;

    localparam int WA = 12;
    localparam int FL = 29;
    localparam int DEPTH = 4;
    localparam logic [17:0] BASE = 18'h08000;
    localparam logic [17:0] RCMD = 18'h00028;
    localparam logic [17:0] RDAT = 18'h0002C;
    localparam logic [17:0] STAT = 18'h00030;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [17:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi;
    logic [2:0]  cs_n;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    spb_bridge dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .ser_clk   (sclk),
        .ser_cs_n  (cs_n),
        .ser_mosi  (mosi),
        .ser_miso  (miso)
    );

    // behavioural slave and shadow memory
    logic [15:0] smem [4096];
    logic [15:0] emem [4096];

    function automatic logic [15:0] seed_val(int i);
        return 16'(i * 499) ^ 16'h5A5A;
    endfunction

    int          fcnt = 0;
    logic        f_rw = 1'b0;
    logic [11:0] f_addr = '0;
    logic [15:0] f_data = '0;
    logic [2:0]  f_cs = 3'b111;
    int          frames = 0;
    int          cs_errs = 0;
    int          last_len = 0;
    logic        cs_any;
    assign cs_any = ~&cs_n;

    always @(posedge cs_any) begin
        fcnt = 0;
        f_cs = cs_n;
        f_addr = '0;
    end

    always @(posedge sclk) begin
        if (cs_any) begin
            fcnt++;
            if (fcnt == 1) f_rw = mosi;
            else if (fcnt <= 1 + WA) f_addr = {f_addr[10:0], mosi};
            else f_data = {f_data[14:0], mosi};
        end
    end

    always @(negedge sclk) begin
        if (cs_any && f_rw && fcnt >= 1 + WA && fcnt < FL) begin
            int idx;
            idx = 15 - (fcnt - 1 - WA);
            miso = smem[f_addr][idx];
        end
    end

    always @(negedge cs_any) begin
        frames++;
        last_len = fcnt;
        if (f_cs != ~(3'b001 << f_addr[11:10])) cs_errs++;
        if (!f_rw && fcnt == FL) smem[f_addr] = f_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = RDAT;
    endtask

    task automatic rd(input logic [17:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic do_read(input logic [31:0] ofs, output logic [31:0] v);
        wr(RCMD, ofs);
        rd(RDAT, v);
        chk("R2 busy after command", 32'(v[31]), 32'd1);
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            rd(RDAT, v);
            if (!v[31]) break;
        end
    endtask

    task automatic wait_quiet();
        logic [31:0] s, b;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            rd(STAT, s);
            rd(RDAT, b);
            if (s[10] && !b[31] && !cs_any) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_word(logic [31:0] ofs, logic [15:0] d);
        return {1'b0, ofs[16:2], d};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev;
        int fr;
        for (int i = 0; i < 4096; i++) begin
            smem[i] = seed_val(i);
            emem[i] = seed_val(i);
        end
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(STAT, v);  chk("R1 status", v, 32'h0000_0400);
        rd(RDAT, v);  chk("R1 result", v, 32'h0);
        chk("R1 chip selects", 32'(cs_n), 32'h7);

        // R2, R3 directed reads
        do_read(32'h124, v);
        chk("R3 read 0x124", v, exp_word(32'h124, emem[12'h049]));
        do_read(32'h2A7, v);
        chk("R3 read 0x2A7 echo", v, exp_word(32'h2A7, emem[12'h0A9]));

        // R4 out-of-range offset
        rd(RDAT, prev);
        fr = frames;
        wr(RCMD, 32'h0000_4000);
        rd(RDAT, v);  chk("R4 no busy", v, prev);
        wr(BASE + 18'h04000, 32'h1111);
        repeat (80) @(negedge clk);
        chk("R4 no frame", 32'(frames), 32'(fr));
        rd(STAT, v);  chk("R4 queue untouched", v, 32'h400);

        // R5 nonexistent slave 3
        wr(RCMD, 32'h0000_3008);
        rd(RDAT, v);  chk("R5 no busy", v, prev);
        wr(BASE + 18'h03008, 32'h2222);
        repeat (80) @(negedge clk);
        chk("R5 no frame", 32'(frames), 32'(fr));

        // R12 writes outside the window
        wr(18'h04000, 32'h3333);
        wr(18'h00044, 32'h4444);
        repeat (80) @(negedge clk);
        chk("R12 no frame", 32'(frames), 32'(fr));

        // R8, R7, R6 burst overfilling the queue
        @(negedge clk);
        for (int k = 0; k < 7; k++) begin
            addr = BASE + 18'(32'h800 + 4 * k);
            wdata = 32'hC000 + 32'(k);
            we = 1'b1;
            @(negedge clk);
        end
        we = 1'b0;
        for (int k = 0; k < DEPTH + 1; k++) emem[12'h200 + 12'(k)] = 16'hC000 + 16'(k);
        rd(STAT, v);  chk("R7 R8 full with overflow", v, 32'h0000_1800);
        do_read(32'h800 + 4 * DEPTH, v);
        chk("R6 read waits for queue", v, exp_word(32'h800 + 4 * DEPTH, emem[12'h200 + 12'(DEPTH)]));
        do_read(32'h800 + 4 * (DEPTH + 1), v);
        chk("R8 dropped write absent", v, exp_word(32'h800 + 4 * (DEPTH + 1), seed_val(12'h200 + DEPTH + 1)));
        rd(STAT, v);  chk("R8 sticky overflow, R7 empty", v, 32'h0000_1400);

        // R11 command while busy
        wr(RCMD, 32'h0000_1010);
        wr(RCMD, 32'h0000_2020);
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            rd(RDAT, v);
            if (!v[31]) break;
        end
        chk("R11 second command ignored", v, exp_word(32'h1010, emem[12'h404]));
        wait_quiet();
        rd(RDAT, v);  chk("R11 no late read", v, exp_word(32'h1010, emem[12'h404]));

        // random mix checked against shadow memory (R6, R3)
        for (int it = 0; it < 60; it++) begin
            logic [1:0]  s;
            logic [11:0] w;
            logic [31:0] ofs;
            logic [15:0] d;
            s = 2'($urandom_range(0, 2));
            w = {s, 10'($urandom)};
            ofs = {16'h0, 2'b00, w, 2'($urandom)};
            if ($urandom_range(0, 2) != 0) begin
                for (int n = 0; n < 1000; n++) begin
                    rd(STAT, v);
                    if (!v[11]) break;
                    @(negedge clk);
                end
                d = 16'($urandom);
                wr(BASE + 18'(ofs), {16'($urandom), d});
                emem[w] = d;
            end else begin
                do_read(ofs, v);
                chk("R6 random read", v, exp_word(ofs, emem[w]));
            end
        end
        wait_quiet();

        chk("R9 chip select per slave", 32'(cs_errs), 32'd0);
        chk("R10 frame length", 32'(last_len), 32'(FL));
        chk("R1 idle chip selects", 32'(cs_n), 32'h7);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule